// File: doc/BRIEF.md
# Serial Signed Fractional Multiplier

This block multiplies two 20-bit two's-complement fractions one multiplier bit at a time. A one-cycle `start` strobe loads the operands. The multiplicand is held in a fixed register, and the multiplier goes into a low register that shares a shift path with the accumulator. The accumulator is one bit wider than an operand, which gives a single 41-bit circulating loop. The multiplier's sign is in the most significant bit and its fraction bits are below it.

The run takes 41 cycles:

- **Cycles 1 to 40 (20 pairs).** Each pair looks at the bit that currently sits at the bottom of the multiplier register. In the first cycle of the pair, the multiplicand is added to the accumulator when that bit is 1. In the second cycle, the accumulator and low register shift right together as one arithmetic shift, which drops the examined bit.
  - For the last pair, the multiplier bit is its sign bit. Here the multiplicand is subtracted instead of added, so a signed multiplier is handled without sign-extending it.
- **Cycle 41.** One left shift of the whole loop places the product's binary point directly right of its sign bit.

After the run, the upper product half is read from `prod_hi` and the lower half from `prod_lo`. `done` is high for one cycle. Both halves then hold until the next run completes.

Top module: `serial_frac_mult`

## Requirements
- R1: While reset is active and after it, `busy` and `done` are 0 and `prod_hi` and `prod_lo` are all zeros.
- R2: A `start` seen on a clock edge while `busy` is 0 captures `mcand` and `mplier` and raises `busy` on that edge.
- R3: `busy` stays 1 for exactly 41 clock cycles. `done` is 1 for exactly the one cycle after `busy` falls, and 0 at all other times.
- R4: When `done` is 1, `{prod_hi, prod_lo}` holds the low 40 bits of twice the signed integer product of the two operands. This means `prod_hi` bit 19 is the product sign and the binary point lies just right of it.
- R5: Negative multiplicands, negative multiplier values and both signs together give the correct two's-complement product, with the multiplier sign bit weighted as -1.
- R6: The most negative operand (0x80000) times itself wraps: `prod_hi` = 0x80000 and `prod_lo` = 0x00000.
- R7: `start` is ignored while `busy` is 1. The run finishes with the product of the operands captured at its own start.
- R8: While `busy` stays 0, `prod_hi` and `prod_lo` hold their values.
- R9: A zero operand on either side gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | 20 | Multiplicand, two's-complement fraction |
| mplier | input | 20 | Multiplier, two's-complement fraction |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: product is final |
| prod_hi | output | 20 | Upper product half, sign bit at bit 19 |
| prod_lo | output | 20 | Lower product half |

## Verification
The operand patterns are chosen so that each one isolates a single part of the datapath:

- **Zero operands and small positive values** show whether the conditional add and the right shift line up bit by bit.
- **A negative multiplicand with a positive multiplier** exercises the sign-extended adds and the arithmetic shift.
- **A negative multiplier** is the only pattern that reaches the final subtract.
- **The most negative value squared** tells a correct wrap apart from a saturating or widened result.
- **Alternating-bit and all-ones patterns** catch a misplaced final left shift or a half swapped between `prod_hi` and `prod_lo`.
- **A second `start` in the middle of a run** separates a block that locks its operands from one that reloads them.

// File: rtl/serial_frac_mult.sv
module serial_frac_mult #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);

  localparam int STEPS = 2 * W + 1;
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] ALIGN = CW'(2 * W);
  localparam logic [CW-1:0] SIGN_ADD = CW'(2 * W - 2);

  logic [W:0]    acc;
  logic [W-1:0]  mq;
  logic [W-1:0]  md;
  logic [CW-1:0] cnt;
  logic          busy_q, done_q;

  wire [W:0] md_x   = {md[W-1], md};
  wire [W:0] addend = (cnt == SIGN_ADD) ? (~md_x + 1'b1) : md_x;
  wire [W:0] sum    = acc + (mq[0] ? addend : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      mq     <= '0;
      md     <= '0;
      cnt    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          md     <= mcand;
          mq     <= mplier;
          acc    <= '0;
          cnt    <= '0;
          busy_q <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == ALIGN) begin
          {acc, mq} <= {acc[W-1:0], mq, 1'b0};
          busy_q    <= 1'b0;
          done_q    <= 1'b1;
        end else if (!cnt[0]) begin
          acc <= sum;
        end else begin
          {acc, mq} <= {acc[W], acc, mq[W-1:1]};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign prod_hi = acc[W-1:0];
  assign prod_lo = mq;

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r3_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt <= ALIGN));

  a_r7_md_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(md));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q)) |-> ($stable(prod_hi) && $stable(prod_lo)));

endmodule

// File: tb/sim_serial_frac_mult.sv
module sim_serial_frac_mult;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int n_chk = 0, n_fail = 0, wd = 0;

  serial_frac_mult #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    longint pa, pb, p;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    p = (pa * pb) <<< 1;
    return p[2*W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: idle/running with a remaining-cycle count
  bit m_busy = 0, m_done = 0;
  int m_left = 0;
  logic [2*W-1:0] m_prod = '0, m_next = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_left <= 0; m_prod <= '0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_left == 1) begin
          m_busy <= 0; m_done <= 1; m_prod <= m_next;
        end
        m_left <= m_left - 1;
      end else if (start) begin
        m_busy <= 1; m_left <= 41; m_next <= ref_prod(mcand, mplier);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == m_busy, "R3 busy", longint'(busy), longint'(m_busy));
      chk(done == m_done, "R3 done", longint'(done), longint'(m_done));
      if (!m_busy)
        chk({prod_hi, prod_lo} == m_prod, "R4/R8 product", longint'({prod_hi, prod_lo}), longint'(m_prod));
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string req);
    logic [2*W-1:0] e;
    int cyc;
    e = ref_prod(a, b);
    @(negedge clk);
    start = 1; mcand = a; mplier = b;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
    cyc = 0;
    while (!done) begin
      if (busy) cyc++;
      if (poke && cyc == 5) begin
        start = 1; mcand = ~a; mplier = b ^ 20'h5A5A5;
      end else begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0;
    chk(cyc == 41, "R3 busy length", longint'(cyc), 41);
    chk({prod_hi, prod_lo} == e, req, longint'({prod_hi, prod_lo}), longint'(e));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 flags in reset", longint'({busy, done}), 0);
    chk({prod_hi, prod_lo} == '0, "R1 product in reset", longint'({prod_hi, prod_lo}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && {prod_hi, prod_lo} == '0, "R1 after reset", longint'({busy, done, prod_hi, prod_lo}), 0);

    run(20'h00000, 20'h3ABCD, 0, "R9 zero multiplicand");
    run(20'h5ABCD, 20'h00000, 0, "R9 zero multiplier");
    run(20'h00003, 20'h00005, 0, "R4 small positive");
    run(20'h40000, 20'h40000, 0, "R4 half times half");
    run(20'hC0000, 20'h40000, 0, "R5 negative multiplicand");
    run(20'h40000, 20'hC0000, 0, "R5 negative multiplier");
    run(20'hB1234, 20'hE9876, 0, "R5 both negative");
    run(20'hFFFFF, 20'hFFFFF, 0, "R5 all ones");
    run(20'hAAAAA, 20'h55555, 0, "R4 alternating");
    run(20'h80000, 20'h7FFFF, 0, "R5 min times max");
    run(20'h80000, 20'h80000, 0, "R6 min squared");
    chk(prod_hi == 20'h80000 && prod_lo == 20'h0, "R6 wrap value", longint'({prod_hi, prod_lo}), longint'(40'h8000000000));
    run(20'h12345, 20'h6789A, 1, "R7 start during run ignored");

    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] a, b;
      a = W'(32'h9E3779B9 * (i + 1) >> 7);
      b = W'(32'h7F4A7C15 * (i + 3) >> 5);
      run(a, b, (i % 4) == 1, "R4/R5 mixed");
    end

    repeat (6) @(negedge clk);
    chk(busy == 0 && done == 0, "R8 idle flags", longint'({busy, done}), 0);
    chk({prod_hi, prod_lo} == m_prod, "R8 product held", longint'({prod_hi, prod_lo}), longint'(m_prod));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule